// File: doc/BRIEF.md
# Shift Status-Flag Unit

This block performs the three plain shifts of a legacy 8/16/32-bit integer datapath (left, logical right, arithmetic right) and forms the six arithmetic status bits that go with them: carry, overflow, auxiliary carry, sign, zero and parity. The status bits follow what real silicon produces, including two values that the architecture leaves undefined. Auxiliary carry is set by every shift that actually moves bits. Right-logical overflow depends only on the operand's top bit, and only for a shift by exactly one.

Each operation is presented with `req_valid` together with the opcode, the operand size, the operand and the raw 8-bit count. Only the low five count bits are used. One clock later the zero-extended result and the status bits appear on registered outputs, with `flags_valid` high. When the five used count bits are all zero, the operation changes nothing: `flags_valid` stays low, and the result and every status bit keep their previous values, so the surrounding core keeps its old status word. Rotates and double-width shifts are handled elsewhere.

Top module: `shflag_unit`

## Requirements
- R1: When `req_valid` is high and `shift_cnt[4:0]` is zero, or when `req_valid` is low, `flags_valid` is low in the next cycle, and `result` and all six status outputs keep their previous values.
- R2: For a valid request with masked count m, `result` holds the operand shifted at the selected width and zero-extended to 32 bits. Left and logical-right shifts of m or more positions than the width give 0. An arithmetic-right shift by that much gives every lane bit equal to the sign. Opcode encoding: 2'b00 left, 2'b01 logical right, 2'b10 arithmetic right, and 2'b11 acts as left. Size encoding: 2'b00 byte, 2'b01 word, 2'b10 or 2'b11 doubleword.
- R3: The auxiliary-carry output is 1 after every valid request, for all three shifts at every width.
- R4: For a left shift, carry is operand bit (width - m) when m is at most the width, and 0 otherwise. In particular, a word shift by 17 to 31 gives carry 0.
- R5: For a logical right shift, carry is operand bit (m - 1), or 0 when m exceeds the width. For an arithmetic right shift, carry is bit (m - 1) of the sign-extended operand.
- R6: For a left shift, overflow is the top lane bit of the result XOR the top lane bit of the operand.
- R7: For a logical right shift, overflow is the operand's top lane bit when m equals 1, and 0 for any other m.
- R8: For an arithmetic right shift, overflow is 0.
- R9: Sign is the top lane bit of the result. Zero is 1 when the result is zero at the selected width. Parity is 1 when the low 8 result bits hold an even number of ones.
- R10: Results appear exactly one cycle after the request, and count bits 7:5 have no effect.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| shift_op | input | 2 | Shift kind (00 left, 01 logical right, 10 arithmetic right) |
| op_size | input | 2 | Lane width (00 byte, 01 word, 1x doubleword) |
| operand | input | 32 | Value to shift, low lane used |
| shift_cnt | input | 8 | Raw count; bits 4:0 used |
| flags_valid | output | 1 | Status bits updated this cycle |
| result | output | 32 | Shifted value, zero-extended |
| cf | output | 1 | Carry |
| of | output | 1 | Overflow |
| af | output | 1 | Auxiliary carry |
| sf | output | 1 | Sign |
| zf | output | 1 | Zero |
| pf | output | 1 | Parity (even) |

## Verification
The directed patterns place a single set bit at each lane boundary, so that the carry for left and right shifts is tied to one exact bit position and an off-by-one index shows up. Counts of 1, 2, the lane width, the width plus one, and 17 to 31 separate the right-shift overflow rule from the left-shift XOR rule and test the word-left carry clearing. Negative operands under arithmetic shift separate sign fill from zero fill. Requests with a zero masked count, including counts whose upper bits are set, show that the outputs hold their previous values. A seeded sweep then mixes all opcodes, sizes and counts and compares every output against a model that shifts one bit at a time.

// File: rtl/shflag_pkg.sv
package shflag_pkg;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RLOG  = 2'b01,
        SH_RARI  = 2'b10,
        SH_ALT   = 2'b11
    } shop_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DALT  = 2'b11
    } opsz_e;

    function automatic logic [6:0] lane_bits(input opsz_e sz);
        unique case (sz)
            SZ_BYTE: lane_bits = 7'd8;
            SZ_WORD: lane_bits = 7'd16;
            default: lane_bits = 7'd32;
        endcase
    endfunction

    function automatic logic [63:0] lane_mask(input opsz_e sz);
        unique case (sz)
            SZ_BYTE: lane_mask = 64'h0000_0000_0000_00FF;
            SZ_WORD: lane_mask = 64'h0000_0000_0000_FFFF;
            default: lane_mask = 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/shflag_shifter.sv
module shflag_shifter
    import shflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  shop_e             op,
    input  opsz_e             size,
    input  logic [DATA_W-1:0] operand,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int EXT_W = 2 * DATA_W;

    logic [6:0]       width;
    logic [EXT_W-1:0] mask;
    logic [EXT_W-1:0] narrow;
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] lsh;
    logic [EXT_W-1:0] rsh;
    logic [SH_W-1:0]  amt_m1;
    logic             sign;

    always_comb begin
        width  = lane_bits(size);
        mask   = lane_mask(size);
        narrow = {{DATA_W{1'b0}}, operand} & mask;
        sign   = narrow[width - 7'd1];
        amt_m1 = (amt == '0) ? '0 : amt - 1'b1;
        ext    = (op == SH_RARI && sign) ? (narrow | ~mask) : narrow;
        lsh    = narrow << amt;
        rsh    = ext >> amt_m1;
        if (op == SH_RLOG || op == SH_RARI) begin
            carry  = rsh[0];
            result = DATA_W'((rsh >> 1) & mask);
        end else begin
            carry  = lsh[width];
            result = DATA_W'(lsh & mask);
        end
    end

endmodule

// File: rtl/shflag_flags.sv
module shflag_flags
    import shflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  shop_e             op,
    input  opsz_e             size,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] result,
    input  logic [SH_W-1:0]   amt,
    output logic              ovf,
    output logic              aux,
    output logic              sgn,
    output logic              zro,
    output logic              par
);
    logic [6:0] width;
    logic       op_top;
    logic       res_top;

    always_comb begin
        width   = lane_bits(size);
        op_top  = operand[width - 7'd1];
        res_top = result[width - 7'd1];
        aux     = |amt;
        sgn     = res_top;
        zro     = ~|result;
        par     = ~^result[7:0];
        unique case (op)
            SH_RLOG: ovf = (amt == SH_W'(1)) ? op_top : 1'b0;
            SH_RARI: ovf = 1'b0;
            default: ovf = res_top ^ op_top;
        endcase
    end

endmodule

// File: rtl/shflag_unit.sv
module shflag_unit
    import shflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        shift_op,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  shift_cnt,
    output logic              flags_valid,
    output logic [DATA_W-1:0] result,
    output logic              cf,
    output logic              of,
    output logic              af,
    output logic              sf,
    output logic              zf,
    output logic              pf
);
    localparam int SH_W = $clog2(DATA_W);

    shop_e             op_e;
    opsz_e             sz_e;
    logic [SH_W-1:0]   amt;
    logic              take;
    logic [DATA_W-1:0] res_d;
    logic              cf_d, of_d, af_d, sf_d, zf_d, pf_d;

    always_comb begin
        op_e = shop_e'(shift_op);
        sz_e = opsz_e'(op_size);
        amt  = shift_cnt[SH_W-1:0];
        take = req_valid && (amt != '0);
    end

    shflag_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .op(op_e), .size(sz_e), .operand(operand), .amt(amt),
        .result(res_d), .carry(cf_d)
    );

    shflag_flags #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
        .op(op_e), .size(sz_e), .operand(operand), .result(res_d), .amt(amt),
        .ovf(of_d), .aux(af_d), .sgn(sf_d), .zro(zf_d), .par(pf_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_valid <= 1'b0;
            result      <= '0;
            {cf, of, af, sf, zf, pf} <= '0;
        end else begin
            flags_valid <= take;
            if (take) begin
                result <= res_d;
                {cf, of, af, sf, zf, pf} <= {cf_d, of_d, af_d, sf_d, zf_d, pf_d};
            end
        end
    end

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!flags_valid && $stable(result) && $stable({cf, of, af, sf, zf, pf})));
    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> flags_valid);
    // R3
    aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> af);
    // R8
    sar_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_e == SH_RARI) |=> !of);
    // R7
    shr_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_e == SH_RLOG && amt != SH_W'(1)) |=> !of);
    // R9
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> (zf == (result == '0)));

endmodule

// File: tb/tb_shflag_unit.sv
module tb_shflag_unit;

    typedef struct {
        logic        v;
        logic [31:0] res;
        logic        cf, of, af, sf, zf, pf;
        logic [1:0]  op;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  shift_op = 2'b00;
    logic [1:0]  op_size = 2'b00;
    logic [31:0] operand = '0;
    logic [7:0]  shift_cnt = '0;
    logic        flags_valid;
    logic [31:0] result;
    logic        cf, of, af, sf, zf, pf;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];
    exp_t last;

    always #4 clk = ~clk;

    shflag_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .shift_op(shift_op),
        .op_size(op_size), .operand(operand), .shift_cnt(shift_cnt),
        .flags_valid(flags_valid), .result(result),
        .cf(cf), .of(of), .af(af), .sf(sf), .zf(zf), .pf(pf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic vld, input logic [1:0] op, input logic [1:0] sz,
                                   input logic [31:0] opnd, input logic [7:0] cnt);
        exp_t e;
        int w;
        int m;
        logic [31:0] v;
        logic c;
        logic s;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = cnt & 8'h1F;
        if (!vld || m == 0) begin
            e = last;
            e.v = 1'b0;
            return e;
        end
        v = (w == 32) ? opnd : (opnd & ((32'd1 << w) - 1));
        s = v[w-1];
        c = 1'b0;
        for (int i = 0; i < m; i++) begin
            if (op == 2'b01 || op == 2'b10) begin
                c = v[0];
                v = v >> 1;
                if (op == 2'b10 && s) v[w-1] = 1'b1;
            end else begin
                c = v[w-1];
                v = v << 1;
                if (w < 32) v = v & ((32'd1 << w) - 1);
            end
        end
        e.v   = 1'b1;
        e.res = v;
        e.cf  = c;
        e.af  = 1'b1;
        e.sf  = v[w-1];
        e.zf  = (v == 0);
        e.pf  = ~^v[7:0];
        e.op  = op;
        if (op == 2'b01)      e.of = (m == 1) ? s : 1'b0;
        else if (op == 2'b10) e.of = 1'b0;
        else                  e.of = v[w-1] ^ s;
        return e;
    endfunction

    task automatic drive(input logic vld, input logic [1:0] op, input logic [1:0] sz,
                         input logic [31:0] opnd, input logic [7:0] cnt);
        exp_t e;
        @(negedge clk);
        req_valid = vld; shift_op = op; op_size = sz; operand = opnd; shift_cnt = cnt;
        e = model(vld, op, sz, opnd, cnt);
        last = e;
        q.push_back(e);
    endtask

    // monitor: one result per cycle, latency one (R10)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("R1 valid", {31'b0, flags_valid}, {31'b0, e.v});
                check("R2 result", result, e.res);
                check((e.op == 2'b00 || e.op == 2'b11) ? "R4 cf" : "R5 cf", {31'b0, cf}, {31'b0, e.cf});
                check(e.op == 2'b01 ? "R7 of" : e.op == 2'b10 ? "R8 of" : "R6 of", {31'b0, of}, {31'b0, e.of});
                check("R3 af", {31'b0, af}, {31'b0, e.af});
                check("R9 sf", {31'b0, sf}, {31'b0, e.sf});
                check("R9 zf", {31'b0, zf}, {31'b0, e.zf});
                check("R9 pf", {31'b0, pf}, {31'b0, e.pf});
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        last = '{v:0, res:0, cf:0, of:0, af:0, sf:0, zf:0, pf:0, op:0};
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check("R11 outputs", {19'b0, flags_valid, cf, of, af, sf, zf, pf, 6'b0}, 32'd0);
        check("R11 result", result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 left carry at lane boundaries
        drive(1, 2'b00, 2'b00, 32'h0000_0081, 8'd1);
        drive(1, 2'b00, 2'b01, 32'h0000_0001, 8'd16);
        drive(1, 2'b00, 2'b01, 32'h0000_FFFF, 8'd17); // R4 word >16 carry 0
        drive(1, 2'b00, 2'b10, 32'h4000_0000, 8'd1);  // R6 overflow
        drive(1, 2'b00, 2'b00, 32'h0000_00FF, 8'd9);
        // R5 / R7 logical right
        drive(1, 2'b01, 2'b00, 32'h0000_0080, 8'd1);
        drive(1, 2'b01, 2'b00, 32'h0000_0080, 8'd2);
        drive(1, 2'b01, 2'b01, 32'h0000_8000, 8'd16);
        drive(1, 2'b01, 2'b10, 32'hFFFF_FFFF, 8'd31);
        drive(1, 2'b01, 2'b00, 32'h0000_00FF, 8'd12);
        // R5 / R8 arithmetic right
        drive(1, 2'b10, 2'b00, 32'h0000_0080, 8'd7);
        drive(1, 2'b10, 2'b00, 32'h0000_0080, 8'd20);
        drive(1, 2'b10, 2'b01, 32'h0000_4001, 8'd1);
        drive(1, 2'b10, 2'b10, 32'h8000_0000, 8'd31);
        // R1 hold: zero masked count, and idle
        drive(1, 2'b00, 2'b10, 32'hDEAD_BEEF, 8'd0);
        drive(1, 2'b01, 2'b00, 32'h0000_0012, 8'hE0); // R10 upper bits ignored
        drive(0, 2'b00, 2'b00, 32'h0000_0001, 8'd3);
        // R10 upper bits ignored on a real shift
        drive(1, 2'b01, 2'b01, 32'h0000_8001, 8'hE1);
        drive(1, 2'b11, 2'b11, 32'h8000_0001, 8'd1);
        // seeded sweep of all kinds (R2, R9)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom(i + 7);
            drive(r[0] | r[1], r[3:2], r[5:4], $urandom, r[15:8] & ((r[6]) ? 8'hFF : 8'h03));
        end
        drive(0, 2'b00, 2'b00, 32'h0, 8'd0);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule